// File: doc/BRIEF.md
# Paged Data-Memory Address Generator

This block produces the 16-bit data-memory address for each operand access of a small DSP-style datapath. It keeps a 9-bit page register. The page register can be loaded from the low bits of a data word fetched from memory, or from a constant taken from the instruction. A direct access places the page register above a 7-bit offset from the instruction. An indirect access uses the full value of the auxiliary register picked by an internal selector. The selector can be given a new value once the access is done.

Two further modes keep only the low 7 bits of the direct or indirect address, which gives access to memory-mapped registers. A reduced legacy mode narrows the page register to one bit. Each requested address is also decoded into a region flag, so the memory system can route the access to page 0, to the on-chip RAM blocks or to the external bus.

Top module: `dmag_addr_gen`

## Requirements
- R1: After reset the page register and the auxiliary-register selector are both 0. A direct request then yields an address equal to the offset, flagged as page-0 region.
- R2: With `addr_mode` = 2'b00 (direct), `addr` = page × 128 + `dir_offset`: the page sits in bits 15:7 and the offset in bits 6:0.
- R3: A pulse on `pg_ld_mem` stores `mem_word[8:0]` into the page register and ignores bits 15:9. The new page applies from the next cycle. A request in the same cycle as the load still uses the old page.
- R4: A pulse on `pg_ld_imm` stores `imm_page` into the page register, with the same one-cycle timing as R3. When both load strobes are high, the immediate load wins.
- R5: With `addr_mode` = 2'b01 (indirect), `addr` is auxiliary register k, where k is the current selector value. Register k occupies `ar_file[16k+15:16k]`.
- R6: An indirect request (mode 2'b01 or 2'b11) with `arp_upd_en` high loads `arp_next` into the selector at the clock edge. The request itself uses the old selector. In all other cycles the selector holds, and its value is visible on `arp_o`.
- R7: With `addr_mode` = 2'b10 (register, direct) or 2'b11 (register, indirect), `addr[15:7]` is 0. `addr[6:0]` equals bits 6:0 of the direct or indirect address respectively, whatever the page register or the auxiliary register holds.
- R8: While `req_valid` is high, exactly one region flag is set, chosen by the address page (addr ÷ 128):
  - page 0, including offsets 96 to 127, sets `rgn_page0`;
  - pages 1 to 3 set `rgn_reserved`;
  - pages 4 to 7 set `rgn_onchip`;
  - page 8 and above sets `rgn_external`.
- R9: While `req_valid` is low, all region flags are 0.
- R10: While `legacy_mode` is high, a page load stores only bit 0 of its source and clears the other bits. A direct address uses only bit 0 of the page register, so page 1 begins at word 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| legacy_mode | input | 1 | One-bit page register mode |
| pg_ld_mem | input | 1 | Load page register from memory word |
| pg_ld_imm | input | 1 | Load page register from immediate |
| mem_word | input | 16 | Data word read from memory |
| imm_page | input | 9 | Immediate page constant |
| req_valid | input | 1 | Address request this cycle |
| addr_mode | input | 2 | 00 direct, 01 indirect, 10 register-direct, 11 register-indirect |
| dir_offset | input | 7 | Instruction offset within page |
| ar_file | input | 128 | Eight auxiliary-register values, register k at bits 16k+15:16k |
| arp_upd_en | input | 1 | Update selector after indirect access |
| arp_next | input | 3 | New selector value |
| addr | output | 16 | Generated data-memory address |
| rgn_page0 | output | 1 | Page 0 registers and scratch region |
| rgn_onchip | output | 1 | On-chip RAM block region |
| rgn_external | output | 1 | External memory region |
| rgn_reserved | output | 1 | Unmapped pages 1 to 3 |
| arp_o | output | 3 | Current auxiliary-register selector |

## Verification
The bench goes after the cycle in which a page load is issued together with a request. A design that forwarded the new page would address the wrong page a cycle early. It drives memory words with bits 15:9 set, which a design that kept wide bits would turn into an external address. It also makes indirect requests that change the selector, where a design that applied the update early would read the wrong auxiliary register. Register-mode accesses with high pages and high auxiliary values show whether the upper bits are really cleared. Pages 3, 4, 7 and 8, and offsets 95 and 96 of page 0, probe the decode boundaries, where an off-by-one would raise the wrong flag.

// File: rtl/dmag_pkg.sv
package dmag_pkg;
  localparam int PAGE_W  = 9;
  localparam int OFS_W   = 7;
  localparam int ADDR_W  = PAGE_W + OFS_W;
  localparam int WORD_W  = 16;
  localparam int ONCHIP_LO = 4;
  localparam int ONCHIP_HI = 7;
  localparam int EXT_LO    = 8;

  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'b00,
    MODE_INDIRECT = 2'b01,
    MODE_REG_DIR  = 2'b10,
    MODE_REG_IND  = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    RGN_PAGE0  = 2'd0,
    RGN_RESV   = 2'd1,
    RGN_ONCHIP = 2'd2,
    RGN_EXT    = 2'd3
  } region_e;

  function automatic logic [ADDR_W-1:0] join_page(input logic [PAGE_W-1:0] pg,
                                                  input logic [OFS_W-1:0] ofs);
    return {pg, ofs};
  endfunction

  function automatic logic [ADDR_W-1:0] keep_low(input logic [ADDR_W-1:0] a);
    return {{PAGE_W{1'b0}}, a[OFS_W-1:0]};
  endfunction

  function automatic region_e region_of(input logic [PAGE_W-1:0] pg);
    if (pg == '0)                                return RGN_PAGE0;
    else if (int'(pg) >= EXT_LO)                 return RGN_EXT;
    else if (int'(pg) >= ONCHIP_LO &&
             int'(pg) <= ONCHIP_HI)              return RGN_ONCHIP;
    else                                         return RGN_RESV;
  endfunction
endpackage

// File: rtl/dmag_page_reg.sv
module dmag_page_reg
  import dmag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              legacy,
  input  logic              ld_mem,
  input  logic              ld_imm,
  input  logic [WORD_W-1:0] mem_word,
  input  logic [PAGE_W-1:0] imm_page,
  output logic [PAGE_W-1:0] page_q
);
  logic [PAGE_W-1:0] ld_src;
  logic [PAGE_W-1:0] ld_val;
  logic              ld_ev;

  assign ld_ev  = ld_mem | ld_imm;
  assign ld_src = ld_imm ? imm_page : mem_word[PAGE_W-1:0];
  assign ld_val = legacy ? {{(PAGE_W-1){1'b0}}, ld_src[0]} : ld_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     page_q <= '0;
    else if (ld_ev) page_q <= ld_val;
  end

  AST_IMM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_imm && !legacy) |=> page_q == $past(imm_page)); // R4
  AST_MEM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_mem && !ld_imm && !legacy) |=> page_q == $past(mem_word[PAGE_W-1:0])); // R3
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ev |=> $stable(page_q)); // R3
  AST_LEGACY_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ev && legacy) |=> page_q[PAGE_W-1:1] == '0); // R10
endmodule

// File: rtl/dmag_arp_reg.sv
module dmag_arp_reg #(
  parameter int ARP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             indirect,
  input  logic             upd_en,
  input  logic [ARP_W-1:0] arp_next,
  output logic [ARP_W-1:0] arp_q
);
  logic arp_upd_ev;
  assign arp_upd_ev = req_valid & indirect & upd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          arp_q <= '0;
    else if (arp_upd_ev) arp_q <= arp_next;
  end

  AST_ARP_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    arp_upd_ev |=> arp_q == $past(arp_next)); // R6
  AST_ARP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !arp_upd_ev |=> $stable(arp_q)); // R6
endmodule

// File: rtl/dmag_region_dec.sv
module dmag_region_dec
  import dmag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [PAGE_W-1:0] page,
  output logic              rgn_page0,
  output logic              rgn_onchip,
  output logic              rgn_external,
  output logic              rgn_reserved
);
  region_e rgn;
  assign rgn = region_of(page);

  always_comb begin
    rgn_page0    = valid && (rgn == RGN_PAGE0);
    rgn_onchip   = valid && (rgn == RGN_ONCHIP);
    rgn_external = valid && (rgn == RGN_EXT);
    rgn_reserved = valid && (rgn == RGN_RESV);
  end

  AST_RGN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $countones({rgn_page0, rgn_onchip, rgn_external, rgn_reserved}) == 1); // R8
  AST_RGN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> {rgn_page0, rgn_onchip, rgn_external, rgn_reserved} == 4'b0000); // R9
  AST_RGN_EXT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && page[PAGE_W-1:3] != '0) |-> rgn_external); // R8
endmodule

// File: rtl/dmag_addr_gen.sv
module dmag_addr_gen
  import dmag_pkg::*;
#(
  parameter int NUM_AR = 8,
  localparam int ARP_W = $clog2(NUM_AR)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     legacy_mode,
  input  logic                     pg_ld_mem,
  input  logic                     pg_ld_imm,
  input  logic [WORD_W-1:0]        mem_word,
  input  logic [PAGE_W-1:0]        imm_page,
  input  logic                     req_valid,
  input  logic [1:0]               addr_mode,
  input  logic [OFS_W-1:0]         dir_offset,
  input  logic [NUM_AR*ADDR_W-1:0] ar_file,
  input  logic                     arp_upd_en,
  input  logic [ARP_W-1:0]         arp_next,
  output logic [ADDR_W-1:0]        addr,
  output logic                     rgn_page0,
  output logic                     rgn_onchip,
  output logic                     rgn_external,
  output logic                     rgn_reserved,
  output logic [ARP_W-1:0]         arp_o
);
  logic [PAGE_W-1:0] page_q;
  logic [PAGE_W-1:0] page_eff;
  logic [ARP_W-1:0]  arp_q;
  logic [ADDR_W-1:0] dir_addr;
  logic [ADDR_W-1:0] ind_addr;
  logic [ADDR_W-1:0] sel_addr;
  logic              mode_ind;
  logic              mode_reg;

  assign mode_ind = addr_mode[0];
  assign mode_reg = addr_mode[1];

  dmag_page_reg u_page (
    .clk      (clk),
    .rst_n    (rst_n),
    .legacy   (legacy_mode),
    .ld_mem   (pg_ld_mem),
    .ld_imm   (pg_ld_imm),
    .mem_word (mem_word),
    .imm_page (imm_page),
    .page_q   (page_q)
  );

  dmag_arp_reg #(.ARP_W(ARP_W)) u_arp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .indirect  (mode_ind),
    .upd_en    (arp_upd_en),
    .arp_next  (arp_next),
    .arp_q     (arp_q)
  );

  assign page_eff = legacy_mode ? {{(PAGE_W-1){1'b0}}, page_q[0]} : page_q;
  assign dir_addr = join_page(page_eff, dir_offset);
  assign ind_addr = ar_file[arp_q*ADDR_W +: ADDR_W];
  assign sel_addr = mode_ind ? ind_addr : dir_addr;
  assign addr     = mode_reg ? keep_low(sel_addr) : sel_addr;
  assign arp_o    = arp_q;

  dmag_region_dec u_rgn (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid        (req_valid),
    .page         (addr[ADDR_W-1:OFS_W]),
    .rgn_page0    (rgn_page0),
    .rgn_onchip   (rgn_onchip),
    .rgn_external (rgn_external),
    .rgn_reserved (rgn_reserved)
  );

  AST_REG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_reg) |-> addr[ADDR_W-1:OFS_W] == '0); // R7
  AST_REG_PAGE0: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_reg) |-> rgn_page0); // R7
  AST_DIRECT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mode_ind) |-> addr[OFS_W-1:0] == dir_offset); // R2
  AST_LEGACY_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && legacy_mode && addr_mode == 2'b00) |-> addr[ADDR_W-1:OFS_W+1] == '0); // R10
endmodule

// File: tb/dmag_addr_gen_tb_top.sv
module dmag_addr_gen_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         legacy_mode = 1'b0;
  logic         pg_ld_mem = 1'b0;
  logic         pg_ld_imm = 1'b0;
  logic [15:0]  mem_word = '0;
  logic [8:0]   imm_page = '0;
  logic         req_valid = 1'b0;
  logic [1:0]   addr_mode = 2'b00;
  logic [6:0]   dir_offset = '0;
  logic [127:0] ar_file = '0;
  logic         arp_upd_en = 1'b0;
  logic [2:0]   arp_next = '0;
  logic [15:0]  addr;
  logic         rgn_page0, rgn_onchip, rgn_external, rgn_reserved;
  logic [2:0]   arp_o;

  int checks = 0;
  int errors = 0;
  logic [8:0] m_page = '0;
  logic [2:0] m_arp = '0;

  always #2 clk = ~clk;

  dmag_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode),
    .pg_ld_mem(pg_ld_mem), .pg_ld_imm(pg_ld_imm), .mem_word(mem_word),
    .imm_page(imm_page), .req_valid(req_valid), .addr_mode(addr_mode),
    .dir_offset(dir_offset), .ar_file(ar_file), .arp_upd_en(arp_upd_en),
    .arp_next(arp_next), .addr(addr), .rgn_page0(rgn_page0),
    .rgn_onchip(rgn_onchip), .rgn_external(rgn_external),
    .rgn_reserved(rgn_reserved), .arp_o(arp_o)
  );

  function automatic logic [15:0] exp_addr();
    int pg;
    int base;
    pg = legacy_mode ? int'(m_page & 9'd1) : int'(m_page);
    if (addr_mode[0]) base = int'(ar_file >> (16 * int'(m_arp))) & 32'hFFFF;
    else              base = pg * 128 + int'(dir_offset);
    if (addr_mode[1]) base = base % 128;
    return base[15:0];
  endfunction

  function automatic logic [3:0] exp_rgn(input logic [15:0] a);
    int pg;
    pg = int'(a) / 128;
    if (!req_valid) return 4'b0000;
    if (pg == 0)    return 4'b1000;
    if (pg < 4)     return 4'b0001;
    if (pg < 8)     return 4'b0100;
    return 4'b0010;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic check_outputs(input string req);
    logic [15:0] ea;
    ea = exp_addr();
    check({req, " addr"}, 32'(addr), 32'(ea));
    check({req, " region"}, 32'({rgn_page0, rgn_onchip, rgn_external, rgn_reserved}), 32'(exp_rgn(ea)));
    check({req, " arp"}, 32'(arp_o), 32'(m_arp));
  endtask

  // Inputs are set after the falling edge; outputs checked 1 ns later; model
  // state advances at the rising edge.
  task automatic step(input string req);
    #1;
    check_outputs(req);
    @(posedge clk);
    if (pg_ld_imm)      m_page = legacy_mode ? {8'd0, imm_page[0]} : imm_page;
    else if (pg_ld_mem) m_page = legacy_mode ? {8'd0, mem_word[0]} : mem_word[8:0];
    if (req_valid && addr_mode[0] && arp_upd_en) m_arp = arp_next;
    @(negedge clk);
    pg_ld_mem = 0; pg_ld_imm = 0; arp_upd_en = 0; req_valid = 0;
  endtask

  task automatic req_dir(input logic [6:0] ofs);
    req_valid = 1; addr_mode = 2'b00; dir_offset = ofs;
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < 8; k++) ar_file[16*k +: 16] = 16'(k * 16'h1111 + 16'h0F80);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    req_dir(7'd45); step("R1");
    // R2 direct with immediate page; R4 same-cycle uses old page
    pg_ld_imm = 1; imm_page = 9'd5; req_dir(7'd3); step("R4");
    req_dir(7'd127); step("R2");
    // R3 high bits of memory word ignored; old page used in load cycle
    pg_ld_mem = 1; mem_word = 16'hFE03; req_dir(7'd1); step("R3");
    req_dir(7'd10); step("R3");
    // R4 both strobes: immediate wins
    pg_ld_mem = 1; mem_word = 16'h0009; pg_ld_imm = 1; imm_page = 9'd7; step("R4");
    req_dir(7'd0); step("R4");
    // R8 boundaries
    pg_ld_imm = 1; imm_page = 9'd3; step("R8");
    req_dir(7'd127); step("R8");
    pg_ld_imm = 1; imm_page = 9'd4; step("R8");
    req_dir(7'd0); step("R8");
    pg_ld_imm = 1; imm_page = 9'd8; step("R8");
    req_dir(7'd0); step("R8");
    pg_ld_imm = 1; imm_page = 9'd0; step("R8");
    req_dir(7'd95); step("R8");
    req_dir(7'd96); step("R8");
    // R9 idle flags
    addr_mode = 2'b00; step("R9");
    // R5/R6 indirect with selector update uses old selector
    req_valid = 1; addr_mode = 2'b01; arp_upd_en = 1; arp_next = 3'd6; step("R6");
    req_valid = 1; addr_mode = 2'b01; step("R5");
    // R6 update ignored without request
    arp_upd_en = 1; arp_next = 3'd2; addr_mode = 2'b01; step("R6");
    // R7 register modes clear upper bits
    pg_ld_imm = 1; imm_page = 9'h1FF; step("R7");
    req_valid = 1; addr_mode = 2'b10; dir_offset = 7'd99; step("R7");
    req_valid = 1; addr_mode = 2'b11; arp_upd_en = 1; arp_next = 3'd7; step("R7");
    req_valid = 1; addr_mode = 2'b11; step("R7");
    // R10 legacy narrowing
    legacy_mode = 1;
    req_dir(7'd5); step("R10");
    pg_ld_imm = 1; imm_page = 9'h0FE; step("R10");
    req_dir(7'd5); step("R10");
    pg_ld_mem = 1; mem_word = 16'hFFFF; step("R10");
    req_dir(7'd5); step("R10");
    legacy_mode = 0;
    req_dir(7'd5); step("R10");
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      legacy_mode = ($urandom % 10) == 0;
      pg_ld_mem   = ($urandom % 4) == 0;
      pg_ld_imm   = ($urandom % 5) == 0;
      mem_word    = 16'($urandom);
      imm_page    = ($urandom % 2) ? 9'($urandom % 12) : 9'($urandom);
      req_valid   = ($urandom % 4) != 0;
      addr_mode   = 2'($urandom);
      dir_offset  = 7'($urandom);
      arp_upd_en  = $urandom % 2;
      arp_next    = 3'($urandom);
      if (($urandom % 50) == 0)
        for (int k = 0; k < 8; k++) ar_file[16*k +: 16] = 16'($urandom);
      step("R8");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule